// File: doc/BRIEF.md
# Biphase-Mark Command Receiver

This block sits on a detector front-end board at the receiving end of a 106 Mbaud command line. The line carries inverted biphase-mark code, which is 53 Mbit/s of data. The block samples the line with a local clock at four samples per data bit and recovers the bits from the position of the transitions. It then searches the bit stream for a 7-bit header. The 5-bit command that follows each header is turned into strobes on six control lines and seven program lines. These lines drive a chain of readout chips.

Most commands produce a single one-clock pulse on one line. A pair of shift commands updates a serial data level that is fanned out to four chip chains, and then pulses a shift clock one cycle later. This recovers the host's shift-clock and shift-data pattern for loading chip registers. A software reset command holds every reset line high for a fixed stretch. Codes without an assignment are dropped.

A broken transition pattern on the line counts as a code violation. It discards the frame in progress, and nothing further is executed until a complete fresh header has been received.

Top module: `cmdlink_rx`

## Requirements
- R1: With four clocks per data bit (two per half cell), a cell that has a transition in its middle decodes as 1 and a cell without one decodes as 0, whatever the idle polarity of the line.
- R2: A code violation discards the frame being received and produces no output. A code violation is either a cell boundary with no transition within five clocks of the previous boundary, or a second transition inside one cell.
- R3: A command is taken only as the 5 bits (first received = most significant) that follow the 7-bit header 1110010 (first received bit on the left). After reset, after an error, and after each command, all 7 header bits must be received again. A frame whose header differs produces no output.
- R4: Code 00001 pulses program line 0, 00101 program line 1, 01000 control line 0, 01010 control line 1, 01011 control line 2, 01100 control line 3 and 11110 control line 4. Each pulse is exactly one clock high, and no other line moves.
- R5: Code 0011d sets all four shift-data lanes (program lines 6..3) to d, and they hold that level. One cycle after the lanes take the new value, the shift clock (program line 2) pulses for exactly one clock.
- R6: Code 11111 holds control line 5, control line 3 and program line 0 high together for exactly 4 consecutive clocks, and clears the shift-data lanes to 0.
- R7: Reserved codes 01101 through 11101, and the unassigned codes 00000, 00010, 00011, 00100 and 01001, change no output.
- R8: While reset is asserted and just after it is released, all control and program lines are low.
- R9: Two frames sent back to back, with no idle bit between them, are both executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, four cycles per data bit |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Received biphase-mark line, asynchronous to clk |
| ctrlLines | output | 6 | 0 trigger accept, 1 token read clock, 2 crossing clock, 3 data reset, 4 software preset, 5 software reset |
| progLines | output | 3+NUM_LANES (7) | 0 program reset, 1 load/kill, 2 shift clock, 6..3 shift-data lanes |

## Verification
The frame interpreter hands off a finished command and restarts its header hunt in the same cycle. The boundary transition that completes the last command bit of one frame is also the opening edge of the first header bit of the next frame. The bench provokes this with frames sent back to back and with random commands separated by short idle gaps. It judges the result by counting the rising edges and measuring the high width of every strobe line over each frame, and by checking the shift-lane level against a model. Code violations injected inside the command field, followed by a clean frame, show that the hunt after an abort needs a complete new header.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

  localparam int CMD_BITS = 5;
  localparam int CTRL_W   = 6;
  localparam int PROG_FIX = 3;

  localparam logic [CMD_BITS-1:0] C_PROG_RESET = 5'b00001;
  localparam logic [CMD_BITS-1:0] C_LOAD_KILL  = 5'b00101;
  localparam logic [CMD_BITS-1:0] C_SHIFT_0    = 5'b00110;
  localparam logic [CMD_BITS-1:0] C_SHIFT_1    = 5'b00111;
  localparam logic [CMD_BITS-1:0] C_TRIG_ACC   = 5'b01000;
  localparam logic [CMD_BITS-1:0] C_TOKEN_CLK  = 5'b01010;
  localparam logic [CMD_BITS-1:0] C_XING_CLK   = 5'b01011;
  localparam logic [CMD_BITS-1:0] C_DATA_RESET = 5'b01100;
  localparam logic [CMD_BITS-1:0] C_SW_PRESET  = 5'b11110;
  localparam logic [CMD_BITS-1:0] C_SW_RESET   = 5'b11111;

  typedef enum logic {HUNT, TAKE_CMD} frame_state_t;

  typedef struct packed {
    logic progReset;
    logic loadKill;
    logic shiftClk;
    logic shiftVal;
    logic trigAccept;
    logic tokenClk;
    logic xingClk;
    logic dataReset;
    logic swPreset;
    logic swReset;
  } strobe_t;

  function automatic strobe_t decodeCmd(input logic [CMD_BITS-1:0] code);
    strobe_t s;
    s = '0;
    case (code)
      C_PROG_RESET: s.progReset  = 1'b1;
      C_LOAD_KILL:  s.loadKill   = 1'b1;
      C_SHIFT_0,
      C_SHIFT_1: begin
        s.shiftClk = 1'b1;
        s.shiftVal = code[0];
      end
      C_TRIG_ACC:   s.trigAccept = 1'b1;
      C_TOKEN_CLK:  s.tokenClk   = 1'b1;
      C_XING_CLK:   s.xingClk    = 1'b1;
      C_DATA_RESET: s.dataReset  = 1'b1;
      C_SW_PRESET:  s.swPreset   = 1'b1;
      C_SW_RESET:   s.swReset    = 1'b1;
      default:      s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bmc_bit_recover.sv
module bmc_bit_recover #(
  parameter int OVERSAMPLE = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic bitValid,
  output logic bitVal,
  output logic codeViol
);

  localparam int HALF = OVERSAMPLE / 2;
  localparam int CW   = $clog2(OVERSAMPLE + 2);

  logic [2:0]    syncQ;
  logic          lineEdge;
  logic          locked;
  logic          midSeen;
  logic [CW-1:0] cnt;

  assign lineEdge = syncQ[2] ^ syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      locked   <= 1'b0;
      midSeen  <= 1'b0;
      cnt      <= '0;
      bitValid <= 1'b0;
      bitVal   <= 1'b0;
      codeViol <= 1'b0;
    end else begin
      syncQ    <= {syncQ[1:0], lineIn};
      bitValid <= 1'b0;
      codeViol <= 1'b0;
      if (!locked) begin
        if (lineEdge) begin
          locked  <= 1'b1;
          cnt     <= CW'(1);
          midSeen <= 1'b0;
        end
      end else if (lineEdge) begin
        if (cnt >= CW'(OVERSAMPLE - 1)) begin
          bitValid <= 1'b1;
          bitVal   <= midSeen;
          cnt      <= CW'(1);
          midSeen  <= 1'b0;
        end else if (cnt >= CW'(HALF - 1) && !midSeen) begin
          midSeen <= 1'b1;
          cnt     <= cnt + 1'b1;
        end else begin
          codeViol <= 1'b1;
          locked   <= 1'b0;
        end
      end else if (cnt == CW'(OVERSAMPLE + 1)) begin
        codeViol <= 1'b1;
        locked   <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmd_frame_ctrl.sv
module cmd_frame_ctrl
  import cmdlink_pkg::*;
#(
  parameter int                  HDR_BITS    = 7,
  parameter logic [HDR_BITS-1:0] HDR_PATTERN = 7'b1110010
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitValid,
  input  logic    bitVal,
  input  logic    codeViol,
  output strobe_t strobe
);

  localparam int NW = $clog2(CMD_BITS + 1);

  frame_state_t        state;
  logic [HDR_BITS-1:0] window;
  logic [HDR_BITS-1:0] nextWin;
  logic [CMD_BITS-2:0] cmdSr;
  logic [NW-1:0]       cmdCnt;

  always_comb nextWin = {window[HDR_BITS-2:0], bitVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= HUNT;
      window <= '0;
      cmdSr  <= '0;
      cmdCnt <= '0;
      strobe <= '0;
    end else begin
      strobe <= '0;
      if (codeViol) begin
        state  <= HUNT;
        window <= '0;
        cmdCnt <= '0;
      end else if (bitValid) begin
        if (state == HUNT) begin
          if (nextWin == HDR_PATTERN) begin
            state  <= TAKE_CMD;
            window <= '0;
            cmdCnt <= '0;
          end else begin
            window <= nextWin;
          end
        end else if (cmdCnt == NW'(CMD_BITS - 1)) begin
          strobe <= decodeCmd({cmdSr, bitVal});
          state  <= HUNT;
          cmdCnt <= '0;
        end else begin
          cmdSr  <= {cmdSr[CMD_BITS-3:0], bitVal};
          cmdCnt <= cmdCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cmd_line_dp.sv
module cmd_line_dp
  import cmdlink_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int RESET_HOLD = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobe,
  output logic [CTRL_W-1:0]             ctrlLines,
  output logic [PROG_FIX+NUM_LANES-1:0] progLines
);

  localparam int HW = $clog2(RESET_HOLD + 1);

  logic                 trigQ, tokenQ, xingQ, dataRstQ, presetQ;
  logic                 progRstQ, loadKillQ, shiftClkQ1, shiftClkQ2;
  logic [NUM_LANES-1:0] lanesQ;
  logic [HW-1:0]        holdCnt;
  logic                 holding;

  assign holding = (holdCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ      <= 1'b0;
      tokenQ     <= 1'b0;
      xingQ      <= 1'b0;
      dataRstQ   <= 1'b0;
      presetQ    <= 1'b0;
      progRstQ   <= 1'b0;
      loadKillQ  <= 1'b0;
      shiftClkQ1 <= 1'b0;
      shiftClkQ2 <= 1'b0;
      lanesQ     <= '0;
      holdCnt    <= '0;
    end else begin
      trigQ      <= strobe.trigAccept;
      tokenQ     <= strobe.tokenClk;
      xingQ      <= strobe.xingClk;
      dataRstQ   <= strobe.dataReset;
      presetQ    <= strobe.swPreset;
      progRstQ   <= strobe.progReset;
      loadKillQ  <= strobe.loadKill;
      shiftClkQ1 <= strobe.shiftClk;
      shiftClkQ2 <= shiftClkQ1;
      if (strobe.swReset) begin
        lanesQ  <= '0;
        holdCnt <= HW'(RESET_HOLD);
      end else begin
        if (strobe.shiftClk) lanesQ <= {NUM_LANES{strobe.shiftVal}};
        if (holding) holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  assign ctrlLines[0] = trigQ;
  assign ctrlLines[1] = tokenQ;
  assign ctrlLines[2] = xingQ;
  assign ctrlLines[3] = dataRstQ | holding;
  assign ctrlLines[4] = presetQ;
  assign ctrlLines[5] = holding;

  assign progLines[0] = progRstQ | holding;
  assign progLines[1] = loadKillQ;
  assign progLines[2] = shiftClkQ2;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign progLines[PROG_FIX+i] = lanesQ[i];
  end

endmodule

// File: rtl/cmdlink_rx.sv
module cmdlink_rx
  import cmdlink_pkg::*;
#(
  parameter int                  OVERSAMPLE  = 4,
  parameter int                  HDR_BITS    = 7,
  parameter logic [HDR_BITS-1:0] HDR_PATTERN = 7'b1110010,
  parameter int                  NUM_LANES   = 4,
  parameter int                  RESET_HOLD  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lineIn,
  output logic [CTRL_W-1:0]             ctrlLines,
  output logic [PROG_FIX+NUM_LANES-1:0] progLines
);

  logic    bitValid, bitVal, codeViol;
  strobe_t strobe;

  bmc_bit_recover #(.OVERSAMPLE(OVERSAMPLE)) uRecover (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .bitValid(bitValid), .bitVal(bitVal), .codeViol(codeViol)
  );

  cmd_frame_ctrl #(.HDR_BITS(HDR_BITS), .HDR_PATTERN(HDR_PATTERN)) uCtrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitVal(bitVal),
    .codeViol(codeViol), .strobe(strobe)
  );

  cmd_line_dp #(.NUM_LANES(NUM_LANES), .RESET_HOLD(RESET_HOLD)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ctrlLines(ctrlLines), .progLines(progLines)
  );

endmodule

// File: rtl/cmdlink_rx_checker.sv
module cmdlink_rx_checker #(
  parameter int CTRL_W     = 6,
  parameter int PROG_W     = 7,
  parameter int RESET_HOLD = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [CTRL_W-1:0] ctrlLines,
  input logic [PROG_W-1:0] progLines
);

  int unsigned runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else if (ctrlLines[5]) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R4: single-clock pulses
  p_trig_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlLines[0] |=> !ctrlLines[0]);
  p_token_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlLines[1] |=> !ctrlLines[1]);
  p_xing_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlLines[2] |=> !ctrlLines[2]);
  p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    progLines[1] |=> !progLines[1]);
  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlLines[0], ctrlLines[1], ctrlLines[2], ctrlLines[4],
              progLines[1], progLines[2]}));

  // R5: shift clock one clock wide, lanes settled a cycle before it rises
  p_shift_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    progLines[2] |=> !progLines[2]);
  p_lane_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progLines[2]) |-> $stable(progLines[PROG_W-1:3]));
  p_lanes_equal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (&progLines[PROG_W-1:3]) || !(|progLines[PROG_W-1:3]));

  // R6: reset stretch
  p_reset_group_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlLines[5] |-> (ctrlLines[3] && progLines[0]));
  p_reset_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlLines[5] |-> (runLen < RESET_HOLD));
  p_reset_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlLines[5]) |-> (runLen == RESET_HOLD));
  p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlLines[5]) |-> !(|progLines[PROG_W-1:3]));

endmodule

bind cmdlink_rx cmdlink_rx_checker #(
  .CTRL_W(cmdlink_pkg::CTRL_W),
  .PROG_W(cmdlink_pkg::PROG_FIX + NUM_LANES),
  .RESET_HOLD(RESET_HOLD)
) uChk (
  .clk(clk), .rstN(rstN), .ctrlLines(ctrlLines), .progLines(progLines)
);

// File: tb/cmdlink_rx_test.sv
module cmdlink_rx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineIn = 1'b0;
  logic [5:0] ctrlLines;
  logic [6:0] progLines;

  always #5 clk = ~clk;

  cmdlink_rx uut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .ctrlLines(ctrlLines), .progLines(progLines)
  );

  localparam logic [6:0] HDR_OK  = 7'b1110010;
  localparam logic [6:0] HDR_BAD = 7'b0110010;

  int checks = 0;
  int errors = 0;
  int pulseCnt [9];
  int maxRun   [9];
  int runLen   [9];
  int setupBad = 0;
  logic       monOn = 1'b0;
  logic       prevShClk = 1'b0;
  logic [3:0] lanesPrev = '0;
  logic       laneExp = 1'b0;

  // Pulse line index: 0..5 control lines, 6 program reset, 7 load/kill, 8 shift clock
  function automatic logic lineAt(int k);
    return (k < 6) ? ctrlLines[k] : progLines[k-6];
  endfunction

  always @(negedge clk) begin
    if (monOn) begin
      for (int k = 0; k < 9; k++) begin
        if (lineAt(k)) begin
          if (runLen[k] == 0) pulseCnt[k]++;
          runLen[k]++;
          if (runLen[k] > maxRun[k]) maxRun[k] = runLen[k];
        end else begin
          runLen[k] = 0;
        end
      end
      if (progLines[2] && !prevShClk && (lanesPrev != progLines[6:3])) setupBad++;
    end
    prevShClk = progLines[2];
    lanesPrev = progLines[6:3];
  end

  function automatic logic [8:0] expMask(logic [4:0] c);
    logic [8:0] m;
    m = '0;
    case (c)
      5'b01000: m[0] = 1'b1;
      5'b01010: m[1] = 1'b1;
      5'b01011: m[2] = 1'b1;
      5'b01100: m[3] = 1'b1;
      5'b11110: m[4] = 1'b1;
      5'b11111: begin m[3] = 1'b1; m[5] = 1'b1; m[6] = 1'b1; end
      5'b00001: m[6] = 1'b1;
      5'b00101: m[7] = 1'b1;
      5'b00110, 5'b00111: m[8] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic string tagFor(logic [4:0] c, logic hdrOk);
    if (!hdrOk) return "R3";
    if (c == 5'b11111) return "R6";
    if (c[4:1] == 4'b0011) return "R5";
    if (expMask(c) == '0) return "R7";
    return "R4";
  endfunction

  task automatic clearStats();
    for (int k = 0; k < 9; k++) begin
      pulseCnt[k] = 0; maxRun[k] = 0; runLen[k] = 0;
    end
    setupBad = 0;
    monOn = 1'b1;
  endtask

  task automatic sendCell(logic b);
    @(negedge clk); lineIn = ~lineIn;
    @(negedge clk);
    @(negedge clk); if (b) lineIn = ~lineIn;
    @(negedge clk);
  endtask

  task automatic sendBits(logic [6:0] hdr, logic [4:0] cmd);
    for (int i = 6; i >= 0; i--) sendCell(hdr[i]);
    for (int i = 4; i >= 0; i--) sendCell(cmd[i]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) sendCell(1'b0);
  endtask

  // expCnt/expWide are per pulse line; lanes compared with laneExp
  task automatic judge(logic [8:0] mask, logic [1:0] mult, logic wide, string tag);
    int badK;
    int expC, expW;
    badK = -1;
    checks++;
    for (int k = 0; k < 9; k++) begin
      expC = mask[k] ? int'(mult) : 0;
      expW = (wide && (k == 3 || k == 5 || k == 6)) ? 4 : (expC != 0 ? 1 : 0);
      if (badK < 0 && (pulseCnt[k] != expC || maxRun[k] != expW)) begin
        badK = k;
        errors++;
        $display("FAIL %s line %0d pulses=%0d width=%0d expected pulses=%0d width=%0d",
                 tag, k, pulseCnt[k], maxRun[k], expC, expW);
      end
    end
    if (badK < 0 && progLines[6:3] != {4{laneExp}}) begin
      errors++;
      $display("FAIL %s lanes=%b expected=%b", tag, progLines[6:3], {4{laneExp}});
    end else if (badK < 0 && setupBad != 0) begin
      errors++;
      $display("FAIL %s shift clock rose with lanes changing: count=%0d expected=0", tag, setupBad);
    end
  endtask

  task automatic runFrame(logic [6:0] hdr, logic [4:0] cmd, int gap, string tag);
    logic ok;
    ok = (hdr == HDR_OK);
    clearStats();
    sendBits(hdr, cmd);
    idle(gap);
    if (ok && cmd[4:1] == 4'b0011) laneExp = cmd[0];
    if (ok && cmd == 5'b11111) laneExp = 1'b0;
    judge(ok ? expMask(cmd) : 9'd0, 2'd1, ok && cmd == 5'b11111, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] c;
    logic       bad;
    int         gap;
    void'($urandom(32'd20240611));

    // R8: outputs low during and right after reset
    repeat (4) @(negedge clk);
    checks++;
    if (ctrlLines != '0 || progLines != '0) begin
      errors++;
      $display("FAIL R8 in reset ctrl=%b prog=%b expected all zero", ctrlLines, progLines);
    end
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (ctrlLines != '0 || progLines != '0) begin
      errors++;
      $display("FAIL R8 after release ctrl=%b prog=%b expected all zero", ctrlLines, progLines);
    end
    idle(4);

    // R1: mixed ones and zeros decode to token read clock
    runFrame(HDR_OK, 5'b01010, 3, "R1");
    // R4: directed pulse commands
    runFrame(HDR_OK, 5'b01000, 3, "R4");
    runFrame(HDR_OK, 5'b00001, 4, "R4");
    runFrame(HDR_OK, 5'b11110, 3, "R4");
    // R5: shift a one then a zero
    runFrame(HDR_OK, 5'b00111, 3, "R5");
    runFrame(HDR_OK, 5'b00110, 3, "R5");
    runFrame(HDR_OK, 5'b00111, 3, "R5");
    // R6: software reset clears lanes and stretches resets
    runFrame(HDR_OK, 5'b11111, 4, "R6");
    // R7: reserved and unassigned codes
    runFrame(HDR_OK, 5'b01101, 3, "R7");
    runFrame(HDR_OK, 5'b11101, 3, "R7");
    runFrame(HDR_OK, 5'b00000, 3, "R7");
    // R3: header with last bit wrong
    runFrame(7'b1110011, 5'b01000, 3, "R3");

    // R2: missing boundary inside the command field
    clearStats();
    sendBits(HDR_OK, 5'b01011);
    for (int i = 6; i >= 0; i--) sendCell(HDR_OK[i]);
    sendCell(1'b0); sendCell(1'b1);
    repeat (8) @(negedge clk);
    sendCell(1'b0); sendCell(1'b0); sendCell(1'b0);
    idle(4);
    judge(expMask(5'b01011), 2'd1, 1'b0, "R2");

    // R2: extra transition inside one cell
    clearStats();
    for (int i = 6; i >= 0; i--) sendCell(HDR_OK[i]);
    sendCell(1'b0);
    @(negedge clk); lineIn = ~lineIn;
    @(negedge clk); lineIn = ~lineIn;
    @(negedge clk); lineIn = ~lineIn;
    @(negedge clk);
    sendCell(1'b1); sendCell(1'b0); sendCell(1'b0);
    idle(4);
    judge(9'd0, 2'd1, 1'b0, "R2");

    // R3: after an abort, a clean frame is accepted
    runFrame(HDR_OK, 5'b01011, 3, "R3");

    // R9: back-to-back frames, no idle in between
    clearStats();
    sendBits(HDR_OK, 5'b01000);
    sendBits(HDR_OK, 5'b00101);
    idle(3);
    judge(expMask(5'b01000) | expMask(5'b00101), 2'd1, 1'b0, "R9");
    clearStats();
    sendBits(HDR_OK, 5'b01011);
    sendBits(HDR_OK, 5'b01011);
    idle(3);
    judge(expMask(5'b01011), 2'd2, 1'b0, "R9");

    // Random commands with occasional corrupted headers
    for (int n = 0; n < 48; n++) begin
      c   = 5'($urandom_range(0, 31));
      bad = ($urandom_range(0, 3) == 0);
      gap = $urandom_range(3, 5);
      runFrame(bad ? HDR_BAD : HDR_OK, c, gap, tagFor(c, !bad));
    end

    monOn = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule